// File: doc/BRIEF.md
# Single-Cycle 16-bit Processor Core

This block is a small processor core that completes one 16-bit instruction on every clock. It fetches through a combinational instruction port, decodes the word, reads three operands from a sixteen-entry register file and writes back in the same cycle. The data memory and the IO port are also combinational on the read side, and the data memory is written at the clock edge. Register 15 holds the program counter, so ordinary register writes can redirect control flow.

The primary opcode sits in the low nibble. The upper three nibbles name the destination, the first source and the second source. Opcode F is an escape: the second-source nibble then selects one of several single-operand or control operations. These are move, two's and one's complement, compare, call, swap and IO read. Loads and stores always address rA + rB. Memory is byte-addressed and little-endian.

Top module: `sc16_core`

## Requirements
- R1: While reset is low and in the first cycle after it, imem_addr is 0 and no data write or IO read is requested. All registers and the C, N and Z flags reset to 0.
- R2: Every instruction that writes neither register 15 nor the PC advances imem_addr by 2. Reading register 15 yields the current address plus 2. Bit 0 of the PC is always 0, and any value written to register 15 has bit 0 cleared.
- R3: Opcode 0 writes the immediate in bits 11-4, sign-extended, to rD. Opcode 1 writes that immediate to bits 15-8 of rD and keeps bits 7-0.
- R4: Opcode 3 loads the 16-bit word at rA+rB. Opcode 2 loads one byte, zero-extended: bits 7-0 of the read word when address bit 0 is 0, and bits 15-8 when it is 1.
- R5: Opcode 5 stores rD with dmem_be = 11. Opcode 4 stores with dmem_be = 01 at an even address and 10 at an odd one, and dmem_wdata carries rD[7:0] in both bytes.
- R6: Opcode 6 adds rA and rB, and opcode 7 also adds C. Both write C with the carry out of bit 15, and write N with bit 15 and Z with result == 0.
- R7: Opcodes 8, 9 and A give AND, OR and XOR of rA and rB. They update N and Z and leave C unchanged.
- R8: Opcodes B, C and D shift rA left, logically right or arithmetically right by rB places, and C takes the last bit shifted out. A shift count of 0 leaves the result equal to rA and C unchanged. Counts of 16 or more give 0, or all sign bits for the arithmetic shift.
- R9: Opcode E branches to (address+2) + 2*sign-extended bits 11-4 when the condition in bits 15-12 holds. The codes are: 0 always, 1 never, 2 Z set, 3 Z clear, 4 N set, 5 N clear, 6 C set, 7 C clear, and 8 to F never.
- R10: Under opcode F, sub-op 1 writes 0-rA with C = (rA == 0), and sub-op 2 writes ~rA with C unchanged. Sub-op 3 sets the flags from rD-rA, with C = carry out (rD >= rA), and writes nothing. Sub-ops 7 to F do nothing but advance the PC.
- R11: Sub-op 0 copies rA to rD; with rD = 15 this is a jump. Sub-op 4 writes address+2 to rD and sets the PC to rA.
- R12: Sub-op 5 exchanges rA and rD. When one of them is register 15, the PC takes the other's value and that register receives address+2.
- R13: Sub-op 6 drives io_addr = rA, raises io_rd for that cycle and writes io_rdata to rD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| imem_addr | output | 16 | Address of the current instruction |
| imem_data | input | 16 | Instruction word at imem_addr |
| dmem_addr | output | 16 | Data address rA + rB |
| dmem_rdata | input | 16 | Word read at dmem_addr (word-aligned) |
| dmem_wdata | output | 16 | Store data |
| dmem_we | output | 1 | Store strobe, taken at the clock edge |
| dmem_be | output | 2 | Byte lanes to write |
| dmem_re | output | 1 | Load in progress |
| io_addr | output | 16 | IO port address |
| io_rdata | input | 16 | IO read data |
| io_rd | output | 1 | IO read strobe |

## Verification
In one cycle a register write that lands on register 15 can coincide with the ordinary PC increment. A word load into the PC, a move to the PC, a call and a swap with the PC each trigger it. The bench issues each of these and compares the next fetch address with a value it computes itself, so the register write must override the increment. Where a register also receives the link value, the bench reads that value out with a store. The ALU operations are swept over every pair drawn from a set of edge values, and the flags are judged through conditional branches.

// File: rtl/sc16_pkg.sv
package sc16_pkg;

  typedef enum logic [3:0] {
    A_ADD, A_ADC, A_AND, A_OR, A_XOR, A_SHL, A_SHR, A_ASR, A_NEG, A_NOT, A_SUB
  } alu_e;

  typedef enum logic [2:0] {
    WB_ALU, WB_IMM, WB_IMMH, WB_MEM, WB_LINK, WB_RA, WB_IO
  } wb_e;

  typedef struct packed {
    alu_e alu;
    wb_e  wb;
    logic wr_d;
    logic wr_a;
    logic set_f;
    logic cmp;
    logic mem_rd;
    logic mem_wr;
    logic mem_byte;
    logic branch;
    logic call;
    logic io_rd;
  } ctl_t;

endpackage

// File: rtl/sc16_regfile.sv
module sc16_regfile #(
  parameter int W    = 16,
  parameter int NREG = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_idx,
  input  logic [AW-1:0] rb_idx,
  input  logic [AW-1:0] rd_idx,
  input  logic [W-1:0]  pc_link,
  output logic [W-1:0]  ra_val,
  output logic [W-1:0]  rb_val,
  output logic [W-1:0]  rd_val,
  input  logic          we0,
  input  logic [AW-1:0] wa0,
  input  logic [W-1:0]  wd0,
  input  logic          we1,
  input  logic [AW-1:0] wa1,
  input  logic [W-1:0]  wd1
);
  localparam logic [AW-1:0] PCIDX = AW'(NREG - 1);

  logic [W-1:0] rq [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == NREG - 1) begin : g_pc_slot
      assign rq[g] = '0;
    end else begin : g_gpr
      logic         hit0, hit1, en;
      logic [W-1:0] nxt;
      always_comb begin
        hit0 = we0 && (wa0 == AW'(g));
        hit1 = we1 && (wa1 == AW'(g));
        en   = hit0 | hit1;
        nxt  = rq[g];
        if (hit1) nxt = wd1;
        if (hit0) nxt = wd0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rq[g] <= '0;
        else if (en) rq[g] <= nxt;
      end
    end
  end

  assign ra_val = (ra_idx == PCIDX) ? pc_link : rq[ra_idx];
  assign rb_val = (rb_idx == PCIDX) ? pc_link : rq[rb_idx];
  assign rd_val = (rd_idx == PCIDX) ? pc_link : rq[rd_idx];

endmodule

// File: rtl/sc16_alu.sv
module sc16_alu
  import sc16_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_e         op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         cwr
);
  localparam int SHW = $clog2(W) + 1;
  localparam int LIM = 2 * W - 1;

  logic [SHW-1:0] amt;
  logic [2*W-1:0] wl, wr, wa;
  logic [W:0]     sum;

  always_comb begin
    amt = (b > W'(LIM)) ? SHW'(LIM) : b[SHW-1:0];
    wl  = {{W{1'b0}}, a} << amt;
    wr  = {a, {W{1'b0}}} >> amt;
    wa  = $signed({a, {W{1'b0}}}) >>> amt;
    sum = '0;
    res = '0;
    cout = 1'b0;
    cwr  = 1'b0;
    unique case (op)
      A_ADD, A_ADC: begin
        sum  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, (op == A_ADC) & cin};
        res  = sum[W-1:0];
        cout = sum[W];
        cwr  = 1'b1;
      end
      A_SUB: begin
        sum  = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
        res  = sum[W-1:0];
        cout = sum[W];
        cwr  = 1'b1;
      end
      A_NEG: begin
        sum  = {1'b0, ~a} + {{W{1'b0}}, 1'b1};
        res  = sum[W-1:0];
        cout = sum[W];
        cwr  = 1'b1;
      end
      A_AND: res = a & b;
      A_OR:  res = a | b;
      A_XOR: res = a ^ b;
      A_NOT: res = ~a;
      A_SHL: begin res = wl[W-1:0];     cout = wl[W];   cwr = (amt != '0); end
      A_SHR: begin res = wr[2*W-1:W];   cout = wr[W-1]; cwr = (amt != '0); end
      A_ASR: begin res = wa[2*W-1:W];   cout = wa[W-1]; cwr = (amt != '0); end
      default: res = a;
    endcase
  end

endmodule

// File: rtl/sc16_decode.sv
module sc16_decode
  import sc16_pkg::*;
(
  input  logic [15:0] instr,
  output ctl_t        ctl
);
  logic [3:0] op, sub;
  assign op  = instr[3:0];
  assign sub = instr[7:4];

  always_comb begin
    ctl = '0;
    ctl.alu = A_ADD;
    ctl.wb  = WB_ALU;
    unique case (op)
      4'h0: begin ctl.wb = WB_IMM;  ctl.wr_d = 1'b1; end
      4'h1: begin ctl.wb = WB_IMMH; ctl.wr_d = 1'b1; end
      4'h2, 4'h3: begin
        ctl.wb = WB_MEM; ctl.wr_d = 1'b1; ctl.mem_rd = 1'b1;
        ctl.mem_byte = (op == 4'h2);
      end
      4'h4, 4'h5: begin ctl.mem_wr = 1'b1; ctl.mem_byte = (op == 4'h4); end
      4'h6, 4'h7, 4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD: begin
        ctl.wr_d = 1'b1; ctl.set_f = 1'b1;
        unique case (op)
          4'h6: ctl.alu = A_ADD;
          4'h7: ctl.alu = A_ADC;
          4'h8: ctl.alu = A_AND;
          4'h9: ctl.alu = A_OR;
          4'hA: ctl.alu = A_XOR;
          4'hB: ctl.alu = A_SHL;
          4'hC: ctl.alu = A_SHR;
          default: ctl.alu = A_ASR;
        endcase
      end
      4'hE: ctl.branch = 1'b1;
      default: begin
        unique case (sub)
          4'h0: begin ctl.wb = WB_RA; ctl.wr_d = 1'b1; end
          4'h1: begin ctl.alu = A_NEG; ctl.wr_d = 1'b1; ctl.set_f = 1'b1; end
          4'h2: begin ctl.alu = A_NOT; ctl.wr_d = 1'b1; ctl.set_f = 1'b1; end
          4'h3: begin ctl.alu = A_SUB; ctl.cmp = 1'b1; ctl.set_f = 1'b1; end
          4'h4: begin ctl.wb = WB_LINK; ctl.wr_d = 1'b1; ctl.call = 1'b1; end
          4'h5: begin ctl.wb = WB_RA; ctl.wr_d = 1'b1; ctl.wr_a = 1'b1; end
          4'h6: begin ctl.wb = WB_IO; ctl.wr_d = 1'b1; ctl.io_rd = 1'b1; end
          default: ;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/sc16_core.sv
module sc16_core
  import sc16_pkg::*;
#(
  parameter int W    = 16,
  parameter int NREG = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] imem_addr,
  input  logic [15:0]  imem_data,
  output logic [W-1:0] dmem_addr,
  input  logic [W-1:0] dmem_rdata,
  output logic [W-1:0] dmem_wdata,
  output logic         dmem_we,
  output logic [1:0]   dmem_be,
  output logic         dmem_re,
  output logic [W-1:0] io_addr,
  input  logic [W-1:0] io_rdata,
  output logic         io_rd
);
  localparam int AW = $clog2(NREG);
  localparam logic [AW-1:0] PCIDX = AW'(NREG - 1);

  ctl_t         ctl;
  logic [AW-1:0] f_d, f_a, f_b;
  logic [3:0]   f_cc;
  logic [7:0]   f_imm;
  logic [W-1:0] pc_q, pc_d, pc_link;
  logic         c_q, n_q, z_q, c_d, n_d, z_d, f_en, c_en;
  logic [W-1:0] ra_v, rb_v, rd_v, alu_a, alu_b, alu_r, ld_v, wb0;
  logic         alu_c, alu_cw, taken;

  assign f_d   = imem_data[12 +: AW];
  assign f_a   = imem_data[8 +: AW];
  assign f_b   = imem_data[4 +: AW];
  assign f_cc  = imem_data[15:12];
  assign f_imm = imem_data[11:4];

  sc16_decode u_dec (.instr(imem_data), .ctl(ctl));

  assign pc_link = pc_q + W'(2);

  sc16_regfile #(.W(W), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(f_a), .rb_idx(f_b), .rd_idx(f_d), .pc_link(pc_link),
    .ra_val(ra_v), .rb_val(rb_v), .rd_val(rd_v),
    .we0(ctl.wr_d), .wa0(f_d), .wd0(wb0),
    .we1(ctl.wr_a), .wa1(f_a), .wd1(rd_v)
  );

  assign alu_a = ctl.cmp ? rd_v : ra_v;
  assign alu_b = ctl.cmp ? ra_v : rb_v;

  sc16_alu #(.W(W)) u_alu (
    .op(ctl.alu), .a(alu_a), .b(alu_b), .cin(c_q),
    .res(alu_r), .cout(alu_c), .cwr(alu_cw)
  );

  // Data side
  assign dmem_addr  = ra_v + rb_v;
  assign dmem_wdata = ctl.mem_byte ? {2{rd_v[7:0]}} : rd_v;
  assign dmem_we    = ctl.mem_wr;
  assign dmem_re    = ctl.mem_rd;
  assign dmem_be    = !ctl.mem_byte ? 2'b11 : (dmem_addr[0] ? 2'b10 : 2'b01);
  assign io_addr    = ra_v;
  assign io_rd      = ctl.io_rd;
  assign imem_addr  = pc_q;

  always_comb begin
    ld_v = dmem_rdata;
    if (ctl.mem_byte)
      ld_v = {{(W-8){1'b0}}, dmem_addr[0] ? dmem_rdata[15:8] : dmem_rdata[7:0]};
    unique case (ctl.wb)
      WB_IMM:  wb0 = {{(W-8){f_imm[7]}}, f_imm};
      WB_IMMH: wb0 = {f_imm, rd_v[7:0]};
      WB_MEM:  wb0 = ld_v;
      WB_LINK: wb0 = pc_link;
      WB_RA:   wb0 = ra_v;
      WB_IO:   wb0 = io_rdata;
      default: wb0 = alu_r;
    endcase
  end

  // Branch condition
  always_comb begin
    unique case (f_cc)
      4'h0:    taken = 1'b1;
      4'h2:    taken = z_q;
      4'h3:    taken = !z_q;
      4'h4:    taken = n_q;
      4'h5:    taken = !n_q;
      4'h6:    taken = c_q;
      4'h7:    taken = !c_q;
      default: taken = 1'b0;
    endcase
  end

  // Next state: PC and flags
  always_comb begin
    pc_d = pc_link;
    if (ctl.branch && taken)
      pc_d = pc_link + {{(W-9){f_imm[7]}}, f_imm, 1'b0};
    if (ctl.wr_a && f_a == PCIDX) pc_d = rd_v;
    if (ctl.wr_d && f_d == PCIDX) pc_d = wb0;
    if (ctl.call)                 pc_d = ra_v;
    pc_d[0] = 1'b0;
    f_en = ctl.set_f;
    c_en = ctl.set_f & alu_cw;
    n_d  = alu_r[W-1];
    z_d  = (alu_r == '0);
    c_d  = alu_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      n_q  <= 1'b0;
      z_q  <= 1'b0;
      c_q  <= 1'b0;
    end else begin
      pc_q <= pc_d;
      if (f_en) begin
        n_q <= n_d;
        z_q <= z_d;
      end
      if (c_en) c_q <= c_d;
    end
  end

endmodule

// File: rtl/sc16_core_chk.sv
module sc16_core_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] imem_addr,
  input logic [15:0]  imem_data,
  input logic         dmem_we,
  input logic [1:0]   dmem_be,
  input logic [W-1:0] dmem_wdata,
  input logic         io_rd
);
  logic [3:0] op;
  logic       plain;
  assign op    = imem_data[3:0];
  assign plain = (op == 4'h4) || (op == 4'h5) ||
                 ((op != 4'hE) && (op != 4'hF) && (imem_data[15:12] != 4'hF));

  p_pc_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    imem_addr[0] == 1'b0);

  p_seq_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    plain |=> imem_addr == $past(imem_addr) + W'(2));

  p_never_br_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'hE && imem_data[15:12] == 4'h1) |=> imem_addr == $past(imem_addr) + W'(2));

  p_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> (dmem_be == 2'b11 || $countones(dmem_be) == 1));

  p_byte_dup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dmem_we && dmem_be != 2'b11) |-> dmem_wdata[15:8] == dmem_wdata[7:0]);

  p_io_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd |-> !dmem_we);

endmodule

bind sc16_core sc16_core_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
  .dmem_we(dmem_we), .dmem_be(dmem_be), .dmem_wdata(dmem_wdata), .io_rd(io_rd)
);

// File: tb/sc16_core_tb.sv
module sc16_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] imem_addr, imem_data, dmem_addr, dmem_rdata, dmem_wdata;
  logic [15:0] io_addr, io_rdata;
  logic        dmem_we, dmem_re, io_rd;
  logic [1:0]  dmem_be;
  logic [15:0] mem [256];
  int checks = 0, errors = 0, cycles = 0;
  bit c_exp = 1'b0;

  always #10 clk = ~clk;

  sc16_core u_dut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata), .dmem_wdata(dmem_wdata),
    .dmem_we(dmem_we), .dmem_be(dmem_be), .dmem_re(dmem_re),
    .io_addr(io_addr), .io_rdata(io_rdata), .io_rd(io_rd)
  );

  assign dmem_rdata = mem[dmem_addr[8:1]];
  assign io_rdata   = io_addr ^ 16'h5A5A;

  always @(posedge clk) begin
    if (dmem_we) begin
      if (dmem_be[0]) mem[dmem_addr[8:1]][7:0]  <= dmem_wdata[7:0];
      if (dmem_be[1]) mem[dmem_addr[8:1]][15:8] <= dmem_wdata[15:8];
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired got %0d exp <150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic [15:0] rr(input [3:0] d, a, b, op);
    return {d, a, b, op};
  endfunction

  task automatic chk(input string tag, input [15:0] got, input [15:0] exp);
    checks = checks + 1;
    if (got !== exp) begin
      errors = errors + 1;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic step(input [15:0] ins);
    imem_data = ins;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setr(input [3:0] r, input [15:0] v);
    step({r, v[7:0], 4'h0});
    step({r, v[15:8], 4'h1});
  endtask

  // read a register through a word store to address 0 (r14 holds 0)
  task automatic peek(input [3:0] r, output [15:0] v);
    imem_data = rr(r, 4'd14, 4'd14, 4'h5);
    #1 v = dmem_wdata;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic brchk(input string tag, input [3:0] cc, input bit t);
    logic [15:0] p0;
    p0 = imem_addr;
    step({cc, 8'h01, 4'hE});
    chk(tag, imem_addr, p0 + 16'd2 + (t ? 16'd2 : 16'd0));
  endtask

  task automatic fchk(input string tag, input bit c, input bit n, input bit z);
    brchk({tag, " Z"}, 4'h2, z);
    brchk({tag, " N"}, 4'h4, n);
    brchk({tag, " C"}, 4'h6, c);
  endtask

  task automatic ref_alu(input [3:0] op, input [15:0] a, input [15:0] b, input bit cin,
                         output [15:0] r, output bit co, output bit cw);
    int n;
    logic [16:0] s;
    r = a; co = cin; cw = 1'b0;
    n = (b > 16'd17) ? 17 : int'(b);
    case (op)
      4'h6, 4'h7: begin
        s = {1'b0, a} + {1'b0, b} + ((op == 4'h7 && cin) ? 17'd1 : 17'd0);
        r = s[15:0]; co = s[16]; cw = 1'b1;
      end
      4'h8: r = a & b;
      4'h9: r = a | b;
      4'hA: r = a ^ b;
      default: begin
        for (int i = 0; i < n; i++) begin
          if (op == 4'hB) begin co = r[15]; r = {r[14:0], 1'b0}; end
          else if (op == 4'hC) begin co = r[0]; r = {1'b0, r[15:1]}; end
          else begin co = r[0]; r = {r[15], r[15:1]}; end
        end
        cw = (n != 0);
      end
    endcase
  endtask

  function automatic bit cc_exp(input [3:0] cc, input bit c, n, z);
    case (cc)
      4'h0: return 1'b1;
      4'h2: return z;
      4'h3: return !z;
      4'h4: return n;
      4'h5: return !n;
      4'h6: return c;
      4'h7: return !c;
      default: return 1'b0;
    endcase
  endfunction

  logic [15:0] vals [8];
  logic [15:0] got, r, p0;
  bit co, cw;

  initial begin
    vals = '{16'h0000, 16'h0001, 16'h0003, 16'h0010,
             16'h7FFF, 16'h8000, 16'hFFFF, 16'hA5F0};
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0101 + 16'h1357);
    imem_data = 16'h009F;
    #1;
    // R1: reset state
    @(negedge clk);
    chk("R1 pc in reset", imem_addr, 16'h0000);
    chk("R1 no store in reset", {15'b0, dmem_we}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 pc after release", imem_addr, 16'h0000);
    step(16'h009F);
    chk("R10 unused sub-op advances", imem_addr, 16'h0002);
    peek(4'd3, got);
    chk("R1 reg reset value", got, 16'h0000);
    fchk("R1 flags reset", 1'b0, 1'b0, 1'b0);
    setr(4'd14, 16'h0000);

    // R3: immediates
    step({4'd3, 8'h80, 4'h0});
    peek(4'd3, got); chk("R3 ldi sign-extend", got, 16'hFF80);
    step({4'd3, 8'h12, 4'h1});
    peek(4'd3, got); chk("R3 ldih keeps low", got, 16'h1280);
    step({4'd3, 8'h7F, 4'h0});
    peek(4'd3, got); chk("R3 ldi positive", got, 16'h007F);

    // R2: reading r15
    p0 = imem_addr;
    step(rr(4'd5, 4'd15, 4'd0, 4'hF));
    peek(4'd5, got); chk("R2 r15 reads pc+2", got, p0 + 16'd2);

    // R6 R7 R8: binary ALU sweep
    for (int op = 6; op <= 13; op++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          setr(4'd1, vals[i]);
          setr(4'd2, vals[j]);
          ref_alu(4'(op), vals[i], vals[j], c_exp, r, co, cw);
          step(rr(4'd3, 4'd1, 4'd2, 4'(op)));
          if (cw) c_exp = co;
          peek(4'd3, got);
          chk($sformatf("R6 R7 R8 op %0h result", op), got, r);
          fchk($sformatf("R6 R7 R8 op %0h flags", op), c_exp, r[15], r == 16'h0);
        end
      end
    end

    // R10: negate, not, compare
    for (int i = 0; i < 8; i++) begin
      setr(4'd1, vals[i]);
      step(rr(4'd3, 4'd1, 4'h1, 4'hF));
      c_exp = (vals[i] == 16'h0);
      r = 16'h0 - vals[i];
      peek(4'd3, got); chk("R10 negate", got, r);
      fchk("R10 negate flags", c_exp, r[15], r == 16'h0);
      step(rr(4'd3, 4'd1, 4'h2, 4'hF));
      peek(4'd3, got); chk("R10 not", got, ~vals[i]);
      fchk("R10 not flags", c_exp, ~vals[i][15], ~vals[i] == 16'h0);
      for (int j = 0; j < 8; j++) begin
        setr(4'd3, vals[j]);
        step(rr(4'd3, 4'd1, 4'h3, 4'hF));
        r = vals[j] - vals[i];
        c_exp = (vals[j] >= vals[i]);
        peek(4'd3, got); chk("R10 compare leaves rD", got, vals[j]);
        fchk("R10 compare flags", c_exp, r[15], r == 16'h0);
      end
    end

    // R9: all condition codes over three flag states
    for (int s = 0; s < 3; s++) begin
      bit fc, fn, fz;
      setr(4'd1, s == 1 ? 16'hFFFF : (s == 2 ? 16'h8000 : 16'h0000));
      setr(4'd2, s == 1 ? 16'h0001 : 16'h0000);
      step(rr(4'd3, 4'd1, 4'd2, 4'h6));
      fc = (s == 1); fn = (s == 2); fz = (s != 2);
      for (int cc = 0; cc < 16; cc++)
        brchk($sformatf("R9 cond %0h state %0d", cc, s), 4'(cc), cc_exp(4'(cc), fc, fn, fz));
    end
    p0 = imem_addr;
    step({4'h0, 8'hFD, 4'hE});
    chk("R9 backward branch", imem_addr, p0 - 16'd4);

    // R4: loads
    mem[16] = 16'hBEEF;
    setr(4'd1, 16'h0010);
    setr(4'd2, 16'h0010);
    step(rr(4'd3, 4'd1, 4'd2, 4'h3));
    peek(4'd3, got); chk("R4 word load", got, 16'hBEEF);
    step(rr(4'd3, 4'd1, 4'd2, 4'h2));
    peek(4'd3, got); chk("R4 byte load even", got, 16'h00EF);
    setr(4'd2, 16'h0011);
    step(rr(4'd3, 4'd1, 4'd2, 4'h2));
    peek(4'd3, got); chk("R4 byte load odd", got, 16'h00BE);

    // R5: stores
    setr(4'd4, 16'h1357);
    imem_data = rr(4'd4, 4'd1, 4'd2, 4'h4);
    #1;
    chk("R5 byte lanes odd", {14'b0, dmem_be}, 16'h0002);
    chk("R5 byte data dup", dmem_wdata, 16'h5757);
    chk("R5 address", dmem_addr, 16'h0021);
    @(posedge clk); @(negedge clk);
    chk("R5 byte store memory", mem[16], 16'h57EF);
    setr(4'd2, 16'h0012);
    imem_data = rr(4'd4, 4'd1, 4'd2, 4'h5);
    #1 chk("R5 word lanes", {14'b0, dmem_be}, 16'h0003);
    @(posedge clk); @(negedge clk);
    chk("R5 word store memory", mem[17], 16'h1357);

    // R2: load into the PC together with increment
    mem[18] = 16'h0301;
    setr(4'd2, 16'h0014);
    step(rr(4'd15, 4'd1, 4'd2, 4'h3));
    chk("R2 load to pc clears bit0", imem_addr, 16'h0300);

    // R11: jump and call
    setr(4'd1, 16'h0101);
    step(rr(4'd15, 4'd1, 4'd0, 4'hF));
    chk("R11 move to pc", imem_addr, 16'h0100);
    setr(4'd1, 16'h0200);
    p0 = imem_addr;
    step(rr(4'd6, 4'd1, 4'h4, 4'hF));
    chk("R11 call target", imem_addr, 16'h0200);
    peek(4'd6, got); chk("R11 call link", got, p0 + 16'd2);
    setr(4'd7, 16'h4321);
    step(rr(4'd8, 4'd7, 4'h0, 4'hF));
    peek(4'd8, got); chk("R11 move", got, 16'h4321);

    // R12: swap
    setr(4'd1, 16'hAAAA);
    setr(4'd2, 16'h5555);
    step(rr(4'd2, 4'd1, 4'h5, 4'hF));
    peek(4'd1, got); chk("R12 swap rA", got, 16'h5555);
    peek(4'd2, got); chk("R12 swap rD", got, 16'hAAAA);
    setr(4'd1, 16'h0300);
    p0 = imem_addr;
    step(rr(4'd15, 4'd1, 4'h5, 4'hF));
    chk("R12 swap into pc", imem_addr, 16'h0300);
    peek(4'd1, got); chk("R12 swap link", got, p0 + 16'd2);

    // R13: IO read
    setr(4'd1, 16'h0042);
    imem_data = rr(4'd3, 4'd1, 4'h6, 4'hF);
    #1 chk("R13 io strobe", {15'b0, io_rd}, 16'h0001);
    chk("R13 io address", io_addr, 16'h0042);
    @(posedge clk); @(negedge clk);
    peek(4'd3, got); chk("R13 io data", got, 16'h0042 ^ 16'h5A5A);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule